// File: doc/BRIEF.md
# Variable-Length Instruction Chunk Aligner

The aligner sits between instruction fetch and decode. Fetch hands it 32-bit memory words, one per valid/ready handshake. The aligner cuts each word into two 16-bit chunks on halfword boundaries and keeps them in a small queue. From the head of that queue it builds instructions of one to four chunks (16, 32, 48 or 64 bits). An instruction may begin on any halfword, and instructions of different lengths may follow one another in any order. Decode receives one whole instruction per output handshake, together with its length code and the byte address of its first chunk.

A mode input picks big-endian or little-endian byte lanes. In little-endian mode the two halfwords of each word are exchanged before they enter the queue. The half that holds bytes 2 and 3 is therefore consumed first, and existing 32-bit little-endian code keeps its length bits in the first chunk.

Redirects restart the stream. A branch-type redirect must target a 32-bit aligned address, and one that does not is reported as a fault and otherwise ignored. An exception-return redirect may target any halfword. When it lands on the second halfword of a word, the first chunk of the next fetched word is discarded.

Top module: `chunk_aligner`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `out_valid` and `misalign_fault` are 0, `in_ready` is 1 and `out_pc` is 0.
- R2: With `le_mode`=0, the byte at address offset k of a fetched word is on `in_word[8k+7:8k]`. The first chunk is {byte0,byte1} and the second is {byte2,byte3}, with the lower address in the upper byte of the chunk. With `le_mode`=1 the first chunk is `in_word[31:16]` (bytes 3,2) and the second is `in_word[15:0]` (bytes 1,0).
- R3: The length code is bits [15:14] of an instruction's first chunk: 0 means 1 chunk, 1 means 2, 2 means 3 and 3 means 4. `out_len` carries this code.
- R4: `out_insn` holds the chunks of the instruction in the lowest 16×(code+1) bits, with the first chunk in the most significant position. All bits above them are 0.
- R5: `out_pc` is the byte address of the instruction's first chunk. After each output handshake it advances by 2×(code+1).
- R6: The queue holds at most six chunks. `in_ready` is 0 whenever more than four chunks are held, so with the output stalled exactly three words are accepted after a flush. `out_valid` is raised only when every chunk of the head instruction is present.
- R7: While `out_valid` is 1 and `out_ready` is 0 with no redirect, `out_valid`, `out_insn`, `out_len` and `out_pc` keep their values into the next cycle.
- R8: A redirect with `redir_kind`=0 (branch) and address bit 1 clear empties the queue. The next instruction comes from the target, which `out_pc` reports.
- R9: A redirect with `redir_kind`=0 and address bit 1 set raises `misalign_fault` for exactly one cycle, the cycle after the request. The queue, the program counter and the mode are left unchanged.
- R10: A redirect with `redir_kind`=1 (exception return) never faults and may target any halfword. When the target has bit 1 set, the first chunk of the next accepted word is dropped and the next instruction starts at the target.
- R11: During a cycle with `redir_valid`=1, `in_ready` and `out_valid` are 0, so no word is taken and no instruction is handed out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| le_mode | input | 1 | 1 selects little-endian halfword order; change only with a redirect |
| in_valid | input | 1 | Fetched word present |
| in_ready | output | 1 | Aligner can take a word this cycle |
| in_word | input | 32 | Fetched word, byte lane k = address offset k |
| redir_valid | input | 1 | Redirect request |
| redir_kind | input | 1 | 0 = branch/jump/call/return, 1 = exception return |
| redir_addr | input | AW-1 | Target byte address bits [AW-1:1] |
| misalign_fault | output | 1 | One-cycle pulse for a misaligned branch target |
| out_valid | output | 1 | Complete instruction available |
| out_ready | input | 1 | Decode takes the instruction |
| out_insn | output | 64 | Right-aligned instruction, upper bits zero |
| out_len | output | 2 | Length code (chunks minus one) |
| out_pc | output | AW | Byte address of the first chunk |

## Verification
The output side has no added latency. An instruction can be seen at the ports in the cycle after the edge that stores its last chunk. A handshake is judged in the same cycle in which `out_valid` and `out_ready` are both high. So the bench drives its inputs just after the falling edge, lets them settle, and then checks instruction, length and address against a halfword model of the program before the next rising edge. The fault pulse and the queue flush come one edge after a redirect. The bench samples them at the falling edge that follows and checks the pulse again one cycle later, when it must be low.

// File: rtl/ca_pkg.sv
package ca_pkg;
  // width of one aligned instruction chunk
  parameter int CHUNK_W    = 16;
  // bits of the length code carried in the top of the first chunk
  parameter int LEN_W      = 2;
  // largest instruction in chunks
  parameter int MAX_CHUNKS = 1 << LEN_W;

  typedef enum logic {
    RD_BRANCH = 1'b0,
    RD_ERET   = 1'b1
  } redir_kind_e;
endpackage

// File: rtl/ca_lane_order.sv
module ca_lane_order
  import ca_pkg::*;
(
  input  logic [2*CHUNK_W-1:0] word,
  input  logic                 le_mode,
  output logic [CHUNK_W-1:0]   chunk_first,
  output logic [CHUNK_W-1:0]   chunk_second
);
  // byte lane k carries address offset k
  logic [7:0] lane0, lane1, lane2, lane3;

  always_comb begin
    lane0 = word[7:0];
    lane1 = word[15:8];
    lane2 = word[23:16];
    lane3 = word[31:24];
    if (le_mode) begin
      // halves exchanged: bytes 2,3 lead the stream
      chunk_first  = {lane3, lane2};
      chunk_second = {lane1, lane0};
    end else begin
      chunk_first  = {lane0, lane1};
      chunk_second = {lane2, lane3};
    end
  end
endmodule

// File: rtl/ca_chunk_buf.sv
module ca_chunk_buf
  import ca_pkg::*;
#(
  parameter int DEPTH  = 6,
  parameter int MAXPOP = MAX_CHUNKS,
  localparam int CNTW  = $clog2(DEPTH + 1),
  localparam int PW    = $clog2(MAXPOP + 1),
  localparam int WIN   = DEPTH + MAXPOP,
  localparam int IW    = $clog2(WIN)
)(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            flush,
  input  logic [1:0]                      push_n,
  input  logic [CHUNK_W-1:0]              push_a,
  input  logic [CHUNK_W-1:0]              push_b,
  input  logic [PW-1:0]                   pop_n,
  output logic [MAXPOP-1:0][CHUNK_W-1:0]  head,
  output logic [CNTW-1:0]                 cnt
);
  logic [CHUNK_W-1:0] slot_q   [DEPTH];
  logic [CHUNK_W-1:0] slot_nxt [DEPTH];
  logic [CHUNK_W-1:0] window   [WIN];
  logic [CNTW-1:0]    cnt_q, cnt_nxt, remain;
  logic               upd_en;

  // next-state: drop popped chunks from the front, append pushed ones
  always_comb begin
    remain = cnt_q - CNTW'(pop_n);
    for (int i = 0; i < WIN; i++) begin
      window[i] = (i < DEPTH) ? slot_q[i] : '0;
    end
    for (int i = 0; i < DEPTH; i++) begin
      logic [IW-1:0] src;
      int            k;
      src = IW'(i) + IW'(pop_n);
      k   = i - int'(remain);
      if (src < IW'(cnt_q)) begin
        slot_nxt[i] = window[src];
      end else if (k >= 0 && k < int'(push_n)) begin
        slot_nxt[i] = (k == 0) ? push_a : push_b;
      end else begin
        slot_nxt[i] = slot_q[i];
      end
    end
    if (flush) begin
      cnt_nxt = '0;
    end else begin
      cnt_nxt = remain + CNTW'(push_n);
    end
    upd_en = flush || (pop_n != '0) || (push_n != 2'd0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (upd_en) begin
      cnt_q <= cnt_nxt;
    end
  end

  // datapath storage carries no reset
  always_ff @(posedge clk) begin
    if (upd_en && !flush) begin
      for (int i = 0; i < DEPTH; i++) begin
        slot_q[i] <= slot_nxt[i];
      end
    end
  end

  for (genvar j = 0; j < MAXPOP; j++) begin : g_head
    assign head[j] = slot_q[j];
  end

  assign cnt = cnt_q;

  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNTW'(DEPTH));
  // R6
  pop_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    CNTW'(pop_n) <= cnt_q);
  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_n != 2'd0) |-> (int'(cnt_q) - int'(pop_n) + int'(push_n) <= DEPTH));
endmodule

// File: rtl/ca_assemble.sv
module ca_assemble
  import ca_pkg::*;
#(
  parameter int DEPTH  = 6,
  localparam int CNTW  = $clog2(DEPTH + 1),
  localparam int PW    = $clog2(MAX_CHUNKS + 1),
  localparam int IBITS = MAX_CHUNKS * CHUNK_W
)(
  input  logic [MAX_CHUNKS-1:0][CHUNK_W-1:0] head,
  input  logic [CNTW-1:0]                    cnt,
  output logic [LEN_W-1:0]                   code,
  output logic [PW-1:0]                      need,
  output logic                               complete,
  output logic [IBITS-1:0]                   insn
);
  always_comb begin
    code     = head[0][CHUNK_W-1 -: LEN_W];
    need     = PW'(code) + PW'(1);
    complete = (cnt != '0) && (cnt >= CNTW'(need));
    insn     = '0;
    for (int j = 0; j < MAX_CHUNKS; j++) begin
      logic [IBITS-1:0] piece;
      piece = IBITS'(head[j]);
      if (j < int'(need)) begin
        insn = insn | (piece << (CHUNK_W * (int'(need) - 1 - j)));
      end
    end
  end
endmodule

// File: rtl/ca_redirect.sv
module ca_redirect
  import ca_pkg::*;
#(
  parameter int AW   = 32,
  localparam int PW  = $clog2(MAX_CHUNKS + 1)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          redir_valid,
  input  logic          redir_kind,
  input  logic [AW-1:1] redir_addr,
  input  logic          pop_fire,
  input  logic [PW-1:0] pop_n,
  input  logic          word_fire,
  output logic          flush,
  output logic          drop_first,
  output logic          fault,
  output logic [AW-1:0] pc
);
  logic [AW-1:1] pc_q, pc_nxt;
  logic          drop_q, drop_nxt;
  logic          fault_q, fault_nxt;
  logic          bad_target;
  logic          pc_en;

  always_comb begin
    bad_target = redir_valid && (redir_kind == RD_BRANCH) && redir_addr[1];
    flush      = redir_valid && !bad_target;
    fault_nxt  = bad_target;
    pc_en      = flush || pop_fire;
    if (flush) begin
      pc_nxt = redir_addr;
    end else begin
      pc_nxt = pc_q + (AW-1)'(pop_n);
    end
    if (flush) begin
      drop_nxt = redir_addr[1];
    end else if (word_fire) begin
      drop_nxt = 1'b0;
    end else begin
      drop_nxt = drop_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      drop_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      if (pc_en) begin
        pc_q <= pc_nxt;
      end
      drop_q  <= drop_nxt;
      fault_q <= fault_nxt;
    end
  end

  assign pc         = {pc_q, 1'b0};
  assign drop_first = drop_q;
  assign fault      = fault_q;

  // R9
  fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && redir_kind == RD_BRANCH && redir_addr[1]) |=> fault);
  // R10
  eret_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && redir_kind == RD_ERET) |=> !fault);
  // R9
  fault_keeps_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && redir_kind == RD_BRANCH && redir_addr[1]) |=> $stable(pc));
endmodule

// File: rtl/chunk_aligner.sv
module chunk_aligner
  import ca_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DEPTH = 6,
  localparam int CNTW = $clog2(DEPTH + 1),
  localparam int PW   = $clog2(MAX_CHUNKS + 1),
  localparam int WW   = 2 * CHUNK_W,
  localparam int IBITS = MAX_CHUNKS * CHUNK_W
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             le_mode,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WW-1:0]    in_word,
  input  logic             redir_valid,
  input  logic             redir_kind,
  input  logic [AW-1:1]    redir_addr,
  output logic             misalign_fault,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [IBITS-1:0] out_insn,
  output logic [LEN_W-1:0] out_len,
  output logic [AW-1:0]    out_pc
);
  logic [CHUNK_W-1:0]                  c_first, c_second;
  logic [CHUNK_W-1:0]                  push_a, push_b;
  logic [1:0]                          push_n;
  logic [PW-1:0]                       pop_n, need;
  logic [MAX_CHUNKS-1:0][CHUNK_W-1:0]  head;
  logic [CNTW-1:0]                     cnt;
  logic                                complete, flush, drop_first;
  logic                                word_fire, out_fire;

  ca_lane_order u_lanes (
    .word         (in_word),
    .le_mode      (le_mode),
    .chunk_first  (c_first),
    .chunk_second (c_second)
  );

  // handshake and queue control
  always_comb begin
    in_ready  = !redir_valid && (cnt <= CNTW'(DEPTH - 2));
    word_fire = in_valid && in_ready;
    out_valid = complete && !redir_valid;
    out_fire  = out_valid && out_ready;
    pop_n     = out_fire ? need : '0;
    push_a    = drop_first ? c_second : c_first;
    push_b    = c_second;
    if (!word_fire) begin
      push_n = 2'd0;
    end else if (drop_first) begin
      push_n = 2'd1;
    end else begin
      push_n = 2'd2;
    end
  end

  ca_chunk_buf #(.DEPTH(DEPTH), .MAXPOP(MAX_CHUNKS)) u_buf (
    .clk    (clk),
    .rst_n  (rst_n),
    .flush  (flush),
    .push_n (push_n),
    .push_a (push_a),
    .push_b (push_b),
    .pop_n  (pop_n),
    .head   (head),
    .cnt    (cnt)
  );

  ca_assemble #(.DEPTH(DEPTH)) u_asm (
    .head     (head),
    .cnt      (cnt),
    .code     (out_len),
    .need     (need),
    .complete (complete),
    .insn     (out_insn)
  );

  ca_redirect #(.AW(AW)) u_redir (
    .clk         (clk),
    .rst_n       (rst_n),
    .redir_valid (redir_valid),
    .redir_kind  (redir_kind),
    .redir_addr  (redir_addr),
    .pop_fire    (out_fire),
    .pop_n       (pop_n),
    .word_fire   (word_fire),
    .flush       (flush),
    .drop_first  (drop_first),
    .fault       (misalign_fault),
    .pc          (out_pc)
  );

  // R4
  short_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_len == '0) |-> (out_insn[IBITS-1:CHUNK_W] == '0));
  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !redir_valid) |=>
      (redir_valid || (out_valid && $stable(out_insn) && $stable(out_pc))));
  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid);
  // R6
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt > CNTW'(DEPTH - 2)) |-> !in_ready);
  // R11
  redir_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> (!word_fire && !out_fire));
endmodule

// File: tb/sim_chunk_aligner.sv
module sim_chunk_aligner;
  localparam int PROG = 512;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        le_mode;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_word;
  logic        redir_valid;
  logic        redir_kind;
  logic [31:1] redir_addr;
  logic        misalign_fault;
  logic        out_valid;
  logic        out_ready;
  logic [63:0] out_insn;
  logic [1:0]  out_len;
  logic [31:0] out_pc;

  always #2 clk = ~clk;  // 250 MHz

  chunk_aligner u0 (
    .clk (clk), .rst_n (rst_n), .le_mode (le_mode),
    .in_valid (in_valid), .in_ready (in_ready), .in_word (in_word),
    .redir_valid (redir_valid), .redir_kind (redir_kind), .redir_addr (redir_addr),
    .misalign_fault (misalign_fault),
    .out_valid (out_valid), .out_ready (out_ready), .out_insn (out_insn),
    .out_len (out_len), .out_pc (out_pc)
  );

  logic [15:0] prog [PROG];
  bit          isb  [PROG];
  int          checks = 0;
  int          errors = 0;
  int unsigned seed = 32'h1234_5678;
  int unsigned faddr, exp_pc, last_pc;
  int          got, acc_words;
  bit          prev_hold;
  logic [63:0] prev_insn;

  function automatic int unsigned rnd();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // fetched word in byte lanes, per the chunk order of the requirements
  function automatic logic [31:0] lanes(input int unsigned a);
    logic [15:0] c0, c1;
    int h;
    h  = int'((a >> 1) % PROG);
    c0 = prog[h];
    c1 = prog[(h + 1) % PROG];
    if (le_mode) return {c0, c1};
    return {c1[7:0], c1[15:8], c0[7:0], c0[15:8]};
  endfunction

  task automatic step(input bit rdy, input bit feed);
    @(negedge clk);
    redir_valid = 1'b0;
    out_ready   = rdy;
    in_valid    = feed;
    in_word     = lanes(faddr);
    #1;
    if (prev_hold) begin
      // R7
      chk(out_valid && out_insn == prev_insn, "R7 hold", out_insn, prev_insn);
    end
    prev_hold = out_valid && !out_ready;
    prev_insn = out_insn;
    if (in_valid && in_ready) begin
      faddr += 4;
      acc_words++;
    end
    if (out_valid && out_ready) begin
      int          h, n;
      logic [1:0]  code;
      logic [63:0] e;
      h    = int'((exp_pc >> 1) % PROG);
      code = prog[h][15:14];
      n    = int'(code) + 1;
      e    = '0;
      for (int k = 0; k < n; k++) e = (e << 16) | 64'(prog[(h + k) % PROG]);
      chk(out_len == code, "R3 length", 64'(out_len), 64'(code));
      chk(out_insn == e, "R2 R4 insn", out_insn, e);
      chk(out_pc == exp_pc, "R5 pc", 64'(out_pc), 64'(exp_pc));
      last_pc = out_pc;
      exp_pc += 2 * n;
      got++;
    end
  endtask

  task automatic run_stream(input int n, input bit random_ready);
    got = 0;
    while (got < n) step(random_ready ? rnd() % 3 != 0 : 1'b1, 1'b1);
  endtask

  task automatic redirect(input bit kind, input int unsigned addr, input bit le, input bit bad);
    @(negedge clk);
    redir_valid = 1'b1;
    redir_kind  = kind;
    redir_addr  = addr[31:1];
    if (!bad) le_mode = le;
    in_valid    = 1'b1;
    in_word     = lanes(faddr);
    out_ready   = 1'b1;
    #1;
    // R11
    chk(!in_ready, "R11 in_ready", 64'(in_ready), 0);
    chk(!out_valid, "R11 out_valid", 64'(out_valid), 0);
    @(negedge clk);
    redir_valid = 1'b0;
    in_valid    = 1'b0;
    out_ready   = 1'b0;
    #1;
    chk(misalign_fault == bad, bad ? "R9 fault" : "R10 no fault", 64'(misalign_fault), 64'(bad));
    if (!bad) begin
      faddr  = addr & ~32'd3;
      exp_pc = addr;
      chk(!out_valid, "R8 flushed", 64'(out_valid), 0);
    end
    @(negedge clk);
    #1;
    chk(!misalign_fault, "R9 one cycle", 64'(misalign_fault), 0);
    prev_hold = 1'b0;
  endtask

  function automatic int find_b(input int from, input bit odd);
    for (int h = from; h < PROG; h++) if (isb[h] && h[0] == odd) return h;
    return -1;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int h, tgt;
    // build a program of mixed-length instructions
    for (int i = 0; i < PROG; i++) begin prog[i] = '0; isb[i] = 1'b0; end
    h = 0;
    while (h < PROG) begin
      logic [1:0] code;
      code = 2'(rnd() % 4);
      isb[h] = 1'b1;
      for (int k = 0; k <= int'(code); k++) begin
        logic [15:0] v;
        v = 16'(rnd());
        if (k == 0) v[15:14] = code;
        if (h + k < PROG) prog[h + k] = v;
      end
      h += int'(code) + 1;
    end

    rst_n = 1'b0; le_mode = 1'b0; in_valid = 1'b0; in_word = '0;
    redir_valid = 1'b0; redir_kind = 1'b0; redir_addr = '0; out_ready = 1'b0;
    faddr = 0; exp_pc = 0; prev_hold = 1'b0; acc_words = 0;
    repeat (3) @(negedge clk);
    // R1
    chk(!out_valid && !misalign_fault && in_ready, "R1 in reset", {out_valid, misalign_fault, in_ready}, 3'b001);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!out_valid && !misalign_fault && in_ready && out_pc == 0, "R1 after reset",
        {out_valid, misalign_fault, in_ready}, 3'b001);

    // big-endian stream from address 0, decode always ready
    run_stream(60, 1'b0);

    // R8: aligned branch target, little-endian, random decode stalls
    tgt = find_b(100, 1'b0);
    redirect(1'b0, 2 * tgt, 1'b1, 1'b0);
    run_stream(1, 1'b0);
    chk(last_pc == 2 * tgt, "R8 target pc", 64'(last_pc), 64'(2 * tgt));
    run_stream(60, 1'b1);

    // R10: exception return to the second halfword of a word
    tgt = find_b(200, 1'b1);
    redirect(1'b1, 2 * tgt, 1'b1, 1'b0);
    run_stream(1, 1'b0);
    chk(last_pc == 2 * tgt, "R10 target pc", 64'(last_pc), 64'(2 * tgt));
    run_stream(40, 1'b1);

    // R10: exception return to an aligned target, big-endian
    tgt = find_b(30, 1'b0);
    redirect(1'b1, 2 * tgt, 1'b0, 1'b0);
    run_stream(20, 1'b0);

    // R9: misaligned branch is ignored, the stream simply goes on
    redirect(1'b0, 32'd402, 1'b1, 1'b1);
    run_stream(1, 1'b0);
    chk(le_mode == 1'b0, "R9 mode kept", 64'(le_mode), 0);
    run_stream(20, 1'b1);

    // R6/R7: stall decode after a flush; exactly three words fit
    tgt = find_b(300, 1'b0);
    redirect(1'b0, 2 * tgt, 1'b0, 1'b0);
    acc_words = 0;
    for (int c = 0; c < 10; c++) step(1'b0, 1'b1);
    chk(acc_words == 3, "R6 words held", 64'(acc_words), 3);
    chk(!in_ready, "R6 stall", 64'(in_ready), 0);
    chk(out_valid, "R6 head complete", 64'(out_valid), 1);
    run_stream(30, 1'b1);

    // R10 and R2 again in big-endian with odd target
    tgt = find_b(150, 1'b1);
    redirect(1'b1, 2 * tgt, 1'b0, 1'b0);
    run_stream(1, 1'b1);
    chk(last_pc == 2 * tgt, "R10 odd target be", 64'(last_pc), 64'(2 * tgt));
    run_stream(40, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule